// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line back into characters. The line is brought into the clock domain through a synchronizer and then sampled on a single-cycle enable that pulses sixteen times per bit period. A falling edge on the idle line starts a frame. The start bit is checked again half a bit later, and a glitch is discarded there. The data bits, an optional parity bit and the stop bit are then taken at their centres, each one a full bit period after the previous sample.

Each finished character goes into a small receive queue. Beside the character the queue stores three tag bits: a parity mismatch, a low stop bit, and a break. A break is a line held low through the whole frame. The host side sees the oldest entry at the head of the queue and pops it with a read strobe. A character that arrives while the queue is full is thrown away, and a sticky overrun flag records the loss.

Character length, parity enable and parity sense come in as static configuration inputs. They match the settings of the companion transmitter.

Top module: `uart_rx_tag`

## Requirements
- R1: After reset the queue is empty (`fifo_empty`=1, `fifo_full`=0) and `overrun` is 0.
- R2: `cfg_bits` selects the character length (00=5, 01=6, 10=7, 11=8 bits). Data arrives least significant bit first, and stored bits above the character length read as 0.
- R3: When `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 expects even parity and 1 expects odd parity. A mismatch sets the entry's `rd_perr`. When `cfg_par_en`=0 no parity bit is expected and `rd_perr` is 0.
- R4: The line is sampled again OVS/2 enable ticks after the low level is first seen. If it has returned high, the start is dropped and nothing is written.
- R5: A stop bit sampled low sets `rd_ferr` on the entry. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: A frame whose data bits, parity bit (if enabled) and stop bit are all low is stored as exactly one entry with data 0x00, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. Reception resumes after the line returns high.
- R7: The queue holds DEPTH (16) entries. The head is presented on the read outputs without a pop, entries leave in arrival order, and `rd_en` removes the head when the queue is not empty.
- R8: A character completed while the queue is full is discarded, and the queue keeps its contents. `overrun` goes to 1 and stays at 1 until `ovr_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, OVS pulses per bit period |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| cfg_bits | input | 2 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_en | input | 1 | Pop the head entry |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 8 | Head entry character |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_ferr | output | 1 | Head entry framing error tag |
| rd_brk | output | 1 | Head entry break tag |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
The bench uses the defaults DEPTH=16, OVS=16 and SYNC_STAGES=2, with one enable tick every four clocks. The 16-entry depth lets seventeen back-to-back frames reach the full queue and the dropped seventeenth character. OVS=16 puts the start recheck 8 ticks after the edge, so a two-tick glitch can be rejected. All four character lengths are sent, and parity is exercised in both senses, correct and wrong.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int CHAR_W = 8;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              perr;
      logic              ferr;
      logic              brk;
   } rx_entry_t;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_HOLD
   } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b1;
            else if (g == 0) chain[g] <= d_in;
            else chain[g] <= chain[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rx_s,
   input  logic [1:0] cfg_bits,
   input  logic      cfg_par_en,
   input  logic      cfg_par_odd,
   output logic      wr_valid,
   output rx_entry_t wr_entry
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] FULL = CW'(OVS - 1);

   rx_state_t         st;
   logic [CW-1:0]     cnt;
   logic [2:0]        bit_idx;
   logic [CHAR_W-1:0] shreg;
   logic              par_bit;
   logic [2:0]        last_idx;
   logic              is_brk;
   logic              par_bad;

   assign last_idx = 3'd4 + {1'b0, cfg_bits};
   assign is_brk   = (shreg == '0) && !par_bit && !rx_s;
   assign par_bad  = cfg_par_en && ((^shreg) ^ par_bit ^ cfg_par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         wr_valid <= 1'b0;
         wr_entry <= '0;
      end else begin
         wr_valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (tick && !rx_s) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == HALF) begin
                     cnt <= '0;
                     if (!rx_s) begin
                        st      <= RX_DATA;
                        bit_idx <= '0;
                        shreg   <= '0;
                        par_bit <= 1'b0;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (cnt == FULL) begin
                     cnt            <= '0;
                     shreg[bit_idx] <= rx_s;
                     if (bit_idx == last_idx) st <= cfg_par_en ? RX_PAR : RX_STOP;
                     else bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_PAR: begin
               if (tick) begin
                  if (cnt == FULL) begin
                     cnt     <= '0;
                     par_bit <= rx_s;
                     st      <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt == FULL) begin
                     cnt           <= '0;
                     wr_valid      <= 1'b1;
                     wr_entry.data <= shreg;
                     wr_entry.ferr <= !rx_s;
                     wr_entry.brk  <= is_brk;
                     wr_entry.perr <= par_bad && !is_brk;
                     st            <= rx_s ? RX_IDLE : RX_HOLD;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (rx_s) st <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_valid,
   input  rx_entry_t wr_entry,
   input  logic      rd_en,
   output rx_entry_t head,
   output logic      empty,
   output logic      full,
   output logic      wr_drop
);
   localparam int AW = $clog2(DEPTH);

   rx_entry_t     mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [AW:0]   level;
   logic          do_wr;
   logic          do_rd;

   assign empty   = (level == '0);
   assign full    = (level == (AW+1)'(DEPTH));
   assign do_wr   = wr_valid && !full;
   assign do_rd   = rd_en && !empty;
   assign wr_drop = wr_valid && full;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_tag.sv
module uart_rx_tag
   import uart_rx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rx_in,
   input  logic [1:0] cfg_bits,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       rd_en,
   input  logic       ovr_clr,
   output logic [7:0] rd_data,
   output logic       rd_perr,
   output logic       rd_ferr,
   output logic       rd_brk,
   output logic       fifo_empty,
   output logic       fifo_full,
   output logic       overrun
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      rx_s;
   logic      wr_valid;
   rx_entry_t wr_entry;
   rx_entry_t head;
   logic      wr_drop;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .d_out (rx_s)
   );

   uart_rx_frame #(.OVS(OVS)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .rx_s        (rx_s),
      .cfg_bits    (cfg_bits),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .wr_valid    (wr_valid),
      .wr_entry    (wr_entry)
   );

   uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_entry (wr_entry),
      .rd_en    (rd_en),
      .head     (head),
      .empty    (fifo_empty),
      .full     (fifo_full),
      .wr_drop  (wr_drop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (wr_drop) overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
   end

   assign rd_data = head.data;
   assign rd_perr = head.perr;
   assign rd_ferr = head.ferr;
   assign rd_brk  = head.brk;
endmodule

// File: rtl/uart_rx_tag_chk.sv
module uart_rx_tag_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_valid,
   input logic [7:0] wr_data,
   input logic       wr_ferr,
   input logic       wr_perr,
   input logic       wr_brk,
   input logic       rd_en,
   input logic       ovr_clr,
   input logic       fifo_empty,
   input logic       fifo_full,
   input logic       overrun
);
   assert_empty_full_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   assert_stays_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !wr_valid) |=> fifo_empty);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && fifo_full && !rd_en) |=> fifo_full);

   assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(wr_valid && fifo_full));

   assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clr) |=> overrun);

   assert_break_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_brk) |-> (wr_data == 8'h00 && wr_ferr && !wr_perr));
endmodule

bind uart_rx_tag uart_rx_tag_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_data    (wr_entry.data),
   .wr_ferr    (wr_entry.ferr),
   .wr_perr    (wr_entry.perr),
   .wr_brk     (wr_entry.brk),
   .rd_en      (rd_en),
   .ovr_clr    (ovr_clr),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full),
   .overrun    (overrun)
);

// File: tb/uart_rx_tag_bench.sv
`timescale 1ns/1ps
module uart_rx_tag_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] cfg_bits = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       rd_en = 1'b0;
   logic       ovr_clr = 1'b0;
   logic [7:0] rd_data;
   logic       rd_perr, rd_ferr, rd_brk;
   logic       fifo_empty, fifo_full, overrun;

   int checks = 0;
   int errors = 0;
   localparam int BITCLK = 64;

   always #2 clk = ~clk;

   uart_rx_tag u_uart_rx_tag (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
      .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .rd_en(rd_en), .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_perr(rd_perr),
      .rd_ferr(rd_ferr), .rd_brk(rd_brk), .fifo_empty(fifo_empty),
      .fifo_full(fifo_full), .overrun(overrun)
   );

   initial begin
      forever begin
         @(negedge clk) tick16 = 1'b1;
         @(negedge clk) tick16 = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic line_for(input logic v, input int clks);
      rx_in = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] val, input int nbits, input logic pen,
                       input logic podd, input logic flip, input logic stopv);
      logic p;
      cfg_bits    = 2'(nbits - 5);
      cfg_par_en  = pen;
      cfg_par_odd = podd;
      p = 1'b0;
      line_for(1'b0, BITCLK);
      for (int i = 0; i < nbits; i++) begin
         p = p ^ val[i];
         line_for(val[i], BITCLK);
      end
      if (pen) line_for(p ^ podd ^ flip, BITCLK);
      line_for(stopv, BITCLK);
      line_for(1'b1, BITCLK / 2);
   endtask

   task automatic pop_expect(input string tag, input logic [7:0] d, input logic pe,
                             input logic fe, input logic bk);
      chk({tag, " not empty"}, fifo_empty, 1'b0);
      chk({tag, " data"}, rd_data, d);
      chk({tag, " perr"}, rd_perr, pe);
      chk({tag, " ferr"}, rd_ferr, fe);
      chk({tag, " brk"}, rd_brk, bk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 empty", fifo_empty, 1'b1);
      chk("R1 full", fifo_full, 1'b0);
      chk("R1 overrun", overrun, 1'b0);
   endtask

   task automatic t_lengths;
      send(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1);
      pop_expect("R2 8N1", 8'hA5, 1'b0, 1'b0, 1'b0);
      send(8'hFF, 5, 1'b0, 1'b0, 1'b0, 1'b1);
      pop_expect("R2 5N1 upper zero", 8'h1F, 1'b0, 1'b0, 1'b0);
      send(8'h2D, 6, 1'b0, 1'b0, 1'b0, 1'b1);
      pop_expect("R2 6N1", 8'h2D, 1'b0, 1'b0, 1'b0);
      chk("R7 drained", fifo_empty, 1'b1);
   endtask

   task automatic t_parity;
      send(8'h35, 7, 1'b1, 1'b0, 1'b0, 1'b1);
      pop_expect("R3 7E1 good", 8'h35, 1'b0, 1'b0, 1'b0);
      send(8'h35, 7, 1'b1, 1'b0, 1'b1, 1'b1);
      pop_expect("R3 7E1 bad", 8'h35, 1'b1, 1'b0, 1'b0);
      send(8'h16, 5, 1'b1, 1'b1, 1'b0, 1'b1);
      pop_expect("R3 5O1 good", 8'h16, 1'b0, 1'b0, 1'b0);
      send(8'hC3, 8, 1'b1, 1'b1, 1'b1, 1'b1);
      pop_expect("R3 8O1 bad", 8'hC3, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_false_start;
      line_for(1'b0, 8);
      line_for(1'b1, 4 * BITCLK);
      chk("R4 glitch dropped", fifo_empty, 1'b1);
      send(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);
      pop_expect("R4 next char", 8'h5A, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_framing;
      send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      line_for(1'b1, 2 * BITCLK);
      pop_expect("R5 framing", 8'h81, 1'b0, 1'b1, 1'b0);
      chk("R5 single entry", fifo_empty, 1'b1);
   endtask

   task automatic t_break;
      cfg_bits = 2'b11; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
      line_for(1'b0, 20 * BITCLK);
      line_for(1'b1, 2 * BITCLK);
      pop_expect("R6 break", 8'h00, 1'b0, 1'b1, 1'b1);
      chk("R6 one entry", fifo_empty, 1'b1);
      send(8'h3C, 8, 1'b1, 1'b1, 1'b0, 1'b1);
      pop_expect("R6 rearm", 8'h3C, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_overrun;
      for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 8, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 full", fifo_full, 1'b1);
      chk("R8 overrun set", overrun, 1'b1);
      for (int i = 0; i < 16; i++) pop_expect("R7 order", 8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
      chk("R8 17th dropped", fifo_empty, 1'b1);
      chk("R8 sticky", overrun, 1'b1);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      @(negedge clk);
      chk("R8 cleared", overrun, 1'b0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      line_for(1'b1, BITCLK);
      t_lengths();
      t_parity();
      t_false_start();
      t_framing();
      t_break();
      t_overrun();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule